// File: doc/BRIEF.md
# Six-Step Inverter Gate Timing Generator

This block produces the six gate-enable lines for a three-phase bridge that runs in six-step mode. A phase accumulator, advanced each clock by a frequency command word, stands in for a voltage-controlled oscillator. Each time the accumulator wraps, a step counter moves one 5° step around a 72-step electrical cycle. All three legs are sequenced from this one counter, so the output frequency tracks the command word.

Each leg has an upper and a lower switch. Nominally each switch conducts for half the cycle. A programmable dead band, counted in whole steps, is removed from the start of every conduction interval. Because of this, the switch that is turning off is always off before its partner turns on. Phase B lags phase A by one third of the cycle, and phase C lags phase B by the same amount.

The upper switches drive isolating couplers. Their outputs are therefore the timing level ANDed with a square carrier, which is divided down from the system clock. The lower outputs are plain levels. An inhibit line from the overcurrent sensing forces every output off. An enable line stops and rewinds the sequencer.

Top module: `six_step_gate_gen`

## Requirements
- R1: While reset is asserted, and while enable is low after reset, all six gate outputs are 0.
- R2: Every clock in which enable is high adds the frequency word to a 24-bit accumulator. Each wrap of the accumulator advances the step index by one, modulo 72. The outputs are registered, so the outputs after clock edge m show the step index held before that edge. With a word of 0x400000 the step advances once every 4 clocks.
- R3: No leg ever drives its upper output (gate_hi[k]) and its lower output (gate_lo[k]) high at the same time.
- R4: Let d be the effective dead band and p the leg's position (0 to 71). The upper timing level is on for d ≤ p ≤ 35. The lower level is on for 36+d ≤ p ≤ 71. Each switch therefore conducts for 36−d steps; with d=3 this is 33 steps, or 165°.
- R5: A change of the frequency word takes effect from the current accumulator value. The step index never skips a value or moves backwards.
- R6: When enable is low, all outputs are 0 one clock later and the step index returns to 0. After enable rises again, the first outputs show step 0.
- R7: When inhibit is high, all outputs are 0 from the next clock edge on. Sequencing continues underneath, and the outputs return to the current step one clock after inhibit falls.
- R8: The position of leg k (bit k, where A=0, B=1, C=2) is (step − 24·k) mod 72.
- R9: The carrier toggles every car_div+1 clocks, so it has a 50% duty cycle. Each upper output is its timing level ANDed with the carrier. The lower outputs are not gated.
- R10: A dead-band setting above 4 acts as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| en | input | 1 | Run enable; low stops the sequencer and rewinds it to step 0 |
| freq_word | input | 24 | Accumulator increment per clock |
| dead_steps | input | 3 | Dead band in 5° steps; values above 4 are clamped to 4 |
| car_div | input | 8 | Carrier half-period minus one, in clocks |
| inhibit | input | 1 | Forces all gate outputs off |
| gate_hi | output | 3 | Carrier-gated upper-switch enables, one bit per leg (A=bit 0) |
| gate_lo | output | 3 | Lower-switch enable levels, one bit per leg (A=bit 0) |

## Verification
The bench sweeps a full electrical cycle for dead bands of 0, 3 and 6 and compares all six outputs step by step against positions it computes itself. A design with a wrong phase offset, or one that drops the dead band on one edge only, shows mismatched steps and wrong conduction counts; one that fails to clamp a setting of 6 conducts for 30 steps instead of 32. It changes the frequency word mid-cycle and checks the exact clock on which lower A turns on, which exposes a sequencer that restarts or jumps on a word change. It also checks that inhibit blanks the outputs without freezing the sequence, that enable rewinds to step 0, and that the carrier's high and low runs are each car_div+1 clocks; an off-by-one divider gives runs of the wrong length.

// File: rtl/six_step_gate_gen.sv
`timescale 1ns/1ps
module six_step_gate_gen #(
  parameter int ACC_W  = 24,
  parameter int STEPS  = 72,
  parameter int DB_MAX = 4,
  parameter int DB_W   = 3,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [ACC_W-1:0] freq_word,
  input  logic [DB_W-1:0]  dead_steps,
  input  logic [DIV_W-1:0] car_div,
  input  logic             inhibit,
  output logic [2:0]       gate_hi,
  output logic [2:0]       gate_lo
);

  localparam int SW    = $clog2(STEPS);
  localparam int HALF  = STEPS / 2;
  localparam int THIRD = STEPS / 3;

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;
  logic [SW-1:0]    step;
  logic [SW-1:0]    db;
  logic [DIV_W-1:0] cnt;
  logic             car;
  logic [2:0]       hi_lvl;
  logic [2:0]       lo_lvl;

  assign sum = {1'b0, acc} + {1'b0, freq_word};
  assign db  = (int'(dead_steps) > DB_MAX) ? SW'(DB_MAX) : SW'(dead_steps);

  for (genvar k = 0; k < 3; k++) begin : g_leg
    localparam int LAG = (STEPS - k * THIRD) % STEPS;
    logic [SW:0]   wide;
    logic [SW-1:0] pos;
    assign wide = {1'b0, step} + (SW+1)'(LAG);
    assign pos  = (wide >= (SW+1)'(STEPS)) ? SW'(wide - (SW+1)'(STEPS)) : wide[SW-1:0];
    assign hi_lvl[k] = (pos >= db) && (pos < SW'(HALF));
    assign lo_lvl[k] = pos >= (SW'(HALF) + db);

    assert_leg_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
      !(gate_hi[k] && gate_lo[k]));
    assert_dead_gap_R4: assert property (@(posedge clk) disable iff (rst)
      ($fell(gate_lo[k]) && $past(dead_steps) != '0) |-> !gate_hi[k]);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      acc     <= '0;
      step    <= '0;
      cnt     <= '0;
      car     <= 1'b0;
      gate_hi <= '0;
      gate_lo <= '0;
    end else begin
      if (cnt >= car_div) begin
        cnt <= '0;
        car <= ~car;
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (!en) begin
        acc     <= '0;
        step    <= '0;
        gate_hi <= '0;
        gate_lo <= '0;
      end else begin
        acc <= sum[ACC_W-1:0];
        if (sum[ACC_W])
          step <= (step == SW'(STEPS - 1)) ? '0 : step + 1'b1;
        gate_hi <= inhibit ? 3'b000 : (hi_lvl & {3{car}});
        gate_lo <= inhibit ? 3'b000 : lo_lvl;
      end
    end
  end

  assert_step_walk_R5: assert property (@(posedge clk) disable iff (rst)
    (step != $past(step)) |-> (step == '0 || step == SW'($past(step) + 1'b1)));

  assert_idle_when_off_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> (gate_hi == 3'b000 && gate_lo == 3'b000 && step == '0));

  assert_inhibit_blanks_R7: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> (gate_hi == 3'b000 && gate_lo == 3'b000));

endmodule

// File: tb/six_step_gate_gen_test.sv
`timescale 1ns/1ps
module six_step_gate_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        inhibit = 1'b0;
  logic [23:0] fw = '0;
  logic [2:0]  dead = '0;
  logic [7:0]  cdiv = '0;
  logic [2:0]  gh, gl;
  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  six_step_gate_gen uut (
    .clk(clk), .rst(rst), .en(en), .freq_word(fw), .dead_steps(dead),
    .car_div(cdiv), .inhibit(inhibit), .gate_hi(gh), .gate_lo(gl)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp_v);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic bit want(input int s, input int leg, input int d, input bit upper);
    int p, dd;
    p  = (s + 72 - 24 * leg) % 72;
    dd = (d > 4) ? 4 : d;
    return upper ? (p >= dd && p < 36) : (p >= 36 + dd);
  endfunction

  task automatic restart(input logic [23:0] f, input int d, input int div);
    en = 1'b0; inhibit = 1'b0; fw = f; dead = 3'(d); cdiv = 8'(div);
    tick();
    en = 1'b1;
  endtask

  task automatic test_reset();
    tick(); tick();
    chk(gh == 0 && gl == 0, "R1", "outputs in reset", int'({gh, gl}), 0);
    rst = 1'b0;
    tick(); tick();
    chk(gh == 0 && gl == 0, "R1", "outputs with enable low", int'({gh, gl}), 0);
  endtask

  task automatic test_sweep(input int d);
    int mis_hi[3], mis_lo[3], cnt_lo[3];
    int overlap, both_high, dd;
    logic [2:0] h1, l1, h2, l2;
    overlap = 0; both_high = 0;
    dd = (d > 4) ? 4 : d;
    for (int i = 0; i < 3; i++) begin mis_hi[i] = 0; mis_lo[i] = 0; cnt_lo[i] = 0; end
    restart(24'h800000, d, 0);
    for (int s = 0; s < 72; s++) begin
      tick(); h1 = gh; l1 = gl;
      tick(); h2 = gh; l2 = gl;
      overlap += int'(|(h1 & l1)) + int'(|(h2 & l2));
      both_high += int'(|(h1 & h2));
      for (int leg = 0; leg < 3; leg++) begin
        if ((h1[leg] | h2[leg]) != want(s, leg, d, 1'b1)) mis_hi[leg]++;
        if (l1[leg] != want(s, leg, d, 1'b0) || l2[leg] != l1[leg]) mis_lo[leg]++;
        cnt_lo[leg] += int'(l1[leg]);
      end
    end
    for (int leg = 0; leg < 3; leg++) begin
      chk(mis_hi[leg] == 0, "R4/R8", $sformatf("upper steps wrong, leg %0d db %0d", leg, d), mis_hi[leg], 0);
      chk(mis_lo[leg] == 0, "R4/R8", $sformatf("lower steps wrong, leg %0d db %0d", leg, d), mis_lo[leg], 0);
      chk(cnt_lo[leg] == 36 - dd, (d > 4) ? "R10" : "R4",
          $sformatf("lower conduction steps, leg %0d db %0d", leg, d), cnt_lo[leg], 36 - dd);
    end
    chk(overlap == 0, "R3", $sformatf("upper and lower together, db %0d", d), overlap, 0);
    chk(both_high == 0, "R9", "carrier high on two adjacent clocks with divider 0", both_high, 0);
  endtask

  task automatic test_freq();
    restart(24'h400000, 3, 0);
    repeat (156) tick();
    chk(gl[0] == 1'b0, "R2", "lower A before step 39", int'(gl[0]), 0);
    tick();
    chk(gl[0] == 1'b1, "R2", "lower A at step 39", int'(gl[0]), 1);
    restart(24'h800000, 3, 0);
    repeat (40) tick();
    fw = 24'h400000;
    repeat (76) tick();
    chk(gl[0] == 1'b0, "R5", "lower A before step 39 after word change", int'(gl[0]), 0);
    tick();
    chk(gl[0] == 1'b1, "R5", "lower A at step 39 after word change", int'(gl[0]), 1);
  endtask

  task automatic test_enable();
    int nz;
    restart(24'h800000, 3, 0);
    repeat (50) tick();
    en = 1'b0;
    tick();
    chk(gh == 0 && gl == 0, "R6", "outputs one clock after disable", int'({gh, gl}), 0);
    nz = 0;
    repeat (5) begin tick(); if ((gh | gl) != 0) nz++; end
    chk(nz == 0, "R6", "outputs while disabled", nz, 0);
    en = 1'b1;
    tick();
    chk(gl == 3'b010, "R6", "lower outputs at step 0 after re-enable", int'(gl), 2);
  endtask

  task automatic test_inhibit();
    int nz;
    restart(24'h800000, 3, 0);
    repeat (10) tick();
    inhibit = 1'b1;
    tick();
    chk(gh == 0 && gl == 0, "R7", "outputs one clock after inhibit", int'({gh, gl}), 0);
    nz = 0;
    repeat (69) begin tick(); if ((gh | gl) != 0) nz++; end
    chk(nz == 0, "R7", "outputs during inhibit", nz, 0);
    inhibit = 1'b0;
    tick();
    chk(gl == 3'b101, "R7", "lower outputs at step 40 after release", int'(gl), 5);
  endtask

  task automatic test_carrier();
    int guard, hl, ll;
    logic prev;
    restart(24'h000001, 0, 4);
    tick();
    prev = gh[0];
    guard = 0;
    do begin
      prev = gh[0];
      tick();
      guard++;
    end while (!(prev == 1'b0 && gh[0] == 1'b1) && guard < 40);
    hl = 0;
    while (gh[0] && hl < 50) begin hl++; tick(); end
    ll = 0;
    while (!gh[0] && ll < 50) begin
      if (gl != 3'b010) ll = 100;
      ll++; tick();
    end
    chk(hl == 5, "R9", "carrier high run with divider 4", hl, 5);
    chk(ll == 5, "R9", "carrier low run with divider 4", ll, 5);
    chk(gl == 3'b010, "R9", "lower outputs not gated by carrier", int'(gl), 2);
  endtask

  initial begin
    test_reset();
    test_sweep(3);
    test_sweep(0);
    test_sweep(6);
    test_freq();
    test_enable();
    test_inhibit();
    test_carrier();
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL R1 watchdog: run did not complete, got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule